// File: doc/BRIEF.md
# ADC Result Stability Filter

This block sits after an analog-to-digital converter and decides when a fresh conversion result is allowed to reach a status register. Each result arrives with a one-cycle valid strobe. With filtering on, the status register only takes a result once the converter has produced a run of four results in a row whose upper six bits agree. The run test ignores the two least significant bits, so small jitter in the low bits does not stop a run from qualifying. With the bypass input high, every result is copied straight into the status register.

The block drives the status byte and a one-cycle update pulse that tells downstream logic a new value was written. Once a run has qualified, the run count stays saturated. Further matching results keep refreshing the status byte, but they only raise a pulse when the stored byte actually changes. The run tracker keeps counting in both modes, so a run that begins in bypass can complete in filtered mode.

Top module: `adc_stability_filter`

## Requirements
- R1: With `filt_off` high, every strobed result is loaded into `status` at the next clock edge, and `status_upd` is high for that one cycle.
- R2: With `filt_off` low, `status` is loaded only by the result that completes a run of four consecutive strobed results with equal upper bits. That result raises `status_upd` for one cycle, even if its value equals the stored byte.
- R3: The run comparison uses only bits [7:2] of each result. Results that differ only in bits [1:0] still extend a run. The loaded status holds all 8 bits of the result that completed or refreshed the run.
- R4: After reset `status` reads 0x00 and `status_upd` is low.
- R5: A strobed result whose bits [7:2] differ from those of the previous strobed result starts a new run with a length of one. Three more matching results are then needed before a filtered load.
- R6: While a run is saturated, each further matching result in filtered mode is written into `status`. `status_upd` rises only if the byte differs from the stored byte.
- R7: In a cycle without `res_valid`, `status` is unchanged and `status_upd` is low.
- R8: A synchronous active-high `rst` clears the run length, the stored comparison bits and the status byte, so results strobed before reset do not count toward a later run.
- R9: The run length is tracked in both modes. Results strobed in bypass count toward a run that completes after `filt_off` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | One-cycle strobe marking a new conversion result |
| res_data | input | 8 | Conversion result |
| filt_off | input | 1 | 1 = load every result, 0 = load only after a stable run |
| status | output | 8 | Status byte |
| status_upd | output | 1 | One-cycle pulse after each status write that signals new data |

## Verification
Both outputs come from registers. A result strobed before a rising edge shows up in `status` and `status_upd` right after that same edge, and the pulse drops again one edge later. The bench drives inputs on the falling edge and samples both outputs on the next falling edge, exactly one edge after each stimulus. It keeps checking on every idle cycle as well, so a pulse that lasts too long or a load that arrives late is caught. The reset directed tests check at the same point, one edge after `rst` is released or after the first strobe that follows it.

// File: rtl/adcflt_pkg.sv
package adcflt_pkg;

    typedef enum logic {
        MODE_FILTER = 1'b0,
        MODE_BYPASS = 1'b1
    } mode_e;

endpackage

// File: rtl/adcflt_run_tracker.sv
module adcflt_run_tracker #(
    parameter int KEY_W   = 6,
    parameter int RUN_LEN = 4,
    localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             hit_o,
    output logic             first_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t s_d, s_q;
    logic match_d;
    logic [CNT_W-1:0] cnt_nxt_d;

    always_comb begin
        s_d       = s_q;
        hit_o     = 1'b0;
        first_o   = 1'b0;
        match_d   = (s_q.cnt != '0) && (key_i == s_q.key);
        cnt_nxt_d = s_q.cnt;
        if (vld_i) begin
            if (match_d) begin
                cnt_nxt_d = (s_q.cnt == CNT_MAX) ? CNT_MAX : s_q.cnt + CNT_ONE;
            end else begin
                cnt_nxt_d = CNT_ONE;
            end
            s_d.key = key_i;
            s_d.cnt = cnt_nxt_d;
            hit_o   = (cnt_nxt_d == CNT_MAX);
            first_o = hit_o && (s_q.cnt != CNT_MAX);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // the run length never exceeds the qualifying length
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        s_q.cnt <= CNT_MAX);

    // a mismatching key restarts the run at one
    assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (vld_i && s_q.cnt != '0 && key_i != s_q.key) |=> (s_q.cnt == CNT_ONE));

    // with no strobe the tracker state is frozen
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> $stable(s_q));

endmodule

// File: rtl/adcflt_status_reg.sv
module adcflt_status_reg
    import adcflt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vld_i,
    input  logic [DW-1:0] data_i,
    input  mode_e         mode_i,
    input  logic          hit_i,
    input  logic          first_i,
    output logic [DW-1:0] stat_o,
    output logic          upd_o
);

    typedef struct packed {
        logic [DW-1:0] stat;
        logic          upd;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.upd = 1'b0;
        if (vld_i) begin
            if (mode_i == MODE_BYPASS) begin
                s_d.stat = data_i;
                s_d.upd  = 1'b1;
            end else if (hit_i) begin
                s_d.stat = data_i;
                s_d.upd  = first_i || (data_i != s_q.stat);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_o = s_q.stat;
    assign upd_o  = s_q.upd;

    // bypass loads each strobed value and pulses
    assert_bypass_load_R1: assert property (@(posedge clk) disable iff (rst)
        (vld_i && mode_i == MODE_BYPASS) |=> (s_q.stat == $past(data_i) && s_q.upd));

    // filtered strobe that does not complete a run leaves status alone
    assert_filter_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (vld_i && mode_i == MODE_FILTER && !hit_i) |=> ($stable(s_q.stat) && !s_q.upd));

    // no strobe, no change and no pulse
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> ($stable(s_q.stat) && !s_q.upd));

    // run completion always pulses
    assert_first_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (vld_i && mode_i == MODE_FILTER && first_i) |=> s_q.upd);

endmodule

// File: rtl/adc_stability_filter.sv
module adc_stability_filter
    import adcflt_pkg::*;
#(
    parameter int DW      = 8,
    parameter int KEY_W   = 6,
    parameter int RUN_LEN = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          res_valid,
    input  logic [DW-1:0] res_data,
    input  logic          filt_off,
    output logic [DW-1:0] status,
    output logic          status_upd
);

    logic hit_w;
    logic first_w;
    mode_e mode_w;

    assign mode_w = mode_e'(filt_off);

    adcflt_run_tracker #(
        .KEY_W   (KEY_W),
        .RUN_LEN (RUN_LEN)
    ) u_trk (
        .clk     (clk),
        .rst     (rst),
        .vld_i   (res_valid),
        .key_i   (res_data[DW-1 -: KEY_W]),
        .hit_o   (hit_w),
        .first_o (first_w)
    );

    adcflt_status_reg #(
        .DW (DW)
    ) u_stat (
        .clk     (clk),
        .rst     (rst),
        .vld_i   (res_valid),
        .data_i  (res_data),
        .mode_i  (mode_w),
        .hit_i   (hit_w),
        .first_i (first_w),
        .stat_o  (status),
        .upd_o   (status_upd)
    );

    // the status pulse only ever follows a strobe
    assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (rst)
        status_upd |-> $past(res_valid));

    // after reset the outputs are cleared
    assert_reset_clear_R4: assert property (@(posedge clk)
        $past(rst) |-> (status == '0 && !status_upd));

endmodule

// File: tb/sim_adc_stability_filter.sv
module sim_adc_stability_filter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       res_valid = 1'b0;
    logic [7:0] res_data = '0;
    logic       filt_off = 1'b0;
    logic [7:0] status;
    logic       status_upd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adc_stability_filter u0 (
        .clk        (clk),
        .rst        (rst),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .filt_off   (filt_off),
        .status     (status),
        .status_upd (status_upd)
    );

    // {valid, filt_off, data, expected status, expected pulse}
    localparam int NV = 18;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'hA0, 8'h00, 1'b0},  // R5 run starts
        {1'b1, 1'b0, 8'hA1, 8'h00, 1'b0},  // R3 low bits ignored
        {1'b0, 1'b0, 8'hFF, 8'h00, 1'b0},  // R7 idle
        {1'b1, 1'b0, 8'hA2, 8'h00, 1'b0},  // R2 third
        {1'b1, 1'b0, 8'hA3, 8'hA3, 1'b1},  // R2 R3 fourth loads
        {1'b1, 1'b0, 8'hA3, 8'hA3, 1'b0},  // R6 same value
        {1'b1, 1'b0, 8'hA0, 8'hA0, 1'b1},  // R6 changed value
        {1'b1, 1'b0, 8'hB0, 8'hA0, 1'b0},  // R5 mismatch
        {1'b1, 1'b0, 8'hB0, 8'hA0, 1'b0},
        {1'b1, 1'b0, 8'hA0, 8'hA0, 1'b0},  // R5 restart
        {1'b1, 1'b0, 8'hA0, 8'hA0, 1'b0},
        {1'b1, 1'b0, 8'hA0, 8'hA0, 1'b0},
        {1'b1, 1'b0, 8'hA0, 8'hA0, 1'b1},  // R2 completion pulses
        {1'b1, 1'b1, 8'h55, 8'h55, 1'b1},  // R1 bypass
        {1'b1, 1'b1, 8'h55, 8'h55, 1'b1},  // R1
        {1'b1, 1'b1, 8'h56, 8'h56, 1'b1},  // R1
        {1'b1, 1'b0, 8'h57, 8'h57, 1'b1},  // R9 run completes filtered
        {1'b0, 1'b0, 8'h00, 8'h57, 1'b0}   // R7
    };

    task automatic check(input string req, input logic [7:0] exp_s, input logic exp_u);
        n_chk++;
        if (status !== exp_s || status_upd !== exp_u) begin
            n_bad++;
            $display("FAIL %s: status=%02h upd=%0b expected status=%02h upd=%0b",
                     req, status, status_upd, exp_s, exp_u);
        end
    endtask

    task automatic step(input logic v, input logic f, input logic [7:0] d,
                        input string req, input logic [7:0] exp_s, input logic exp_u);
        res_valid = v;
        filt_off  = f;
        res_data  = d;
        @(negedge clk);
        res_valid = 1'b0;
        check(req, exp_s, exp_u);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check("R4", 8'h00, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][18], VEC[i][17], VEC[i][16:9], "R1/R2/R3/R5/R6/R7/R9",
                 VEC[i][8:1], VEC[i][0]);
        end

        // R8: a partial run before reset does not count afterwards
        do_reset();
        check("R4", 8'h00, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'hC0, "R8", 8'h00, 1'b0);
        do_reset();
        step(1'b1, 1'b0, 8'hC0, "R8", 8'h00, 1'b0);
        step(1'b1, 1'b0, 8'hC1, "R8", 8'h00, 1'b0);
        step(1'b1, 1'b0, 8'hC2, "R8", 8'h00, 1'b0);
        step(1'b1, 1'b0, 8'hC0, "R8", 8'hC0, 1'b1);

        // R6: long saturated run stays quiet, then a low-bit change pulses
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 8'hC0, "R6", 8'hC0, 1'b0);
        step(1'b1, 1'b0, 8'hC3, "R6", 8'hC3, 1'b1);
        step(1'b0, 1'b0, 8'h00, "R7", 8'hC3, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule